// File: doc/BRIEF.md
# Per-Core Countdown Timer with Free-Running Tick Counter

The block keeps a per-core time base and a single programmable countdown. A 64-bit counter advances once on every tick strobe from reset onward and never stops. The strobe marks the fixed 10 ns (100 MHz) time base. Next to it sits a countdown armed by software through a 64-bit configuration word. The word holds three things: an enable flag, a mode flag that selects one-shot or periodic operation, and a start count taken from a masked field of the same word.

The countdown expires on the tick that finds it at zero. Each expiry raises a sticky interrupt request, which stays high until a clear pulse arrives from outside. What happens after an expiry depends on the mode. A periodic timer reloads its start count and keeps running. A one-shot timer clears its own enable flag in the stored word and stops.

Software reaches the block through a single-cycle write strobe and a combinational read port. The read port returns one of three values, chosen by a select input: the free-running count, the stored word, or the ticks still left.

Top module: `core_tick_timer`

## Requirements
- R1: After reset the free-running count, the stored word, the remaining ticks and the interrupt request are all zero.
- R2: The free-running count rises by exactly one on every cycle with tick_i high, whether or not the timer is enabled. It holds on cycles without a tick.
- R3: A write stores all 64 bits of wr_data_i as the configuration word. The start count is that word with bits 63:48 and bits 1:0 forced to zero (bits 47:2 kept in place).
- R4: A write with bit 0 (enable) set loads the remaining ticks with the start count and discards any countdown in progress. This also holds when a tick would have expired the old countdown in the same cycle; that expiry is then dropped.
- R5: While enabled, each tick with a non-zero remaining count lowers it by one. A tick that finds it at zero is an expiry, so a start count N expires on the (N+1)-th tick after the load.
- R6: A write with bit 0 clear stops the countdown. Later ticks cause no expiry and leave the remaining count unchanged.
- R7: On expiry with bit 1 (periodic) set, the remaining count reloads from the start count of the stored word, and the enable bit stays set.
- R8: On expiry with bit 1 clear, bit 0 of the stored word is cleared and every other bit is kept. The countdown then stays stopped.
- R9: Every expiry sets irq_o in the following cycle. irq_o then stays high until a cycle with irq_clr_i high, after which it is low.
- R10: When irq_clr_i and an expiry fall in the same cycle, irq_o is high afterwards.
- R11: rd_sel_i selects what rd_data_o returns: 0 the free-running count, 1 the stored word, 2 the remaining ticks (zero-extended), 3 all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per 10 ns time-base tick |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 64 | Configuration word to write |
| rd_sel_i | input | 2 | Read select |
| rd_data_o | output | 64 | Selected read value |
| irq_clr_i | input | 1 | Pulse that clears the interrupt request |
| irq_o | output | 1 | Timer interrupt request |

## Verification
Two pairs of events can land in the same cycle. The first is an expiry together with a clear pulse. The bench provokes it by running a periodic timer down to zero and then driving tick_i and irq_clr_i in the same cycle; irq_o must be high afterwards and the count must have reloaded. The second is an expiry together with an enabling write. The bench provokes it by writing on the tick that would expire the old countdown; the new count must be loaded and irq_o must stay low. Random phases apply ticks, writes and clears freely, and a cycle model written from the requirements judges every read value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned PER_BIT = 1;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_REM  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
  import tmr_pkg::*;
#(
  parameter int unsigned CFG_W    = 64,
  parameter int unsigned INIT_MSB = 47,
  parameter int unsigned INIT_LSB = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  logic [CFG_W-1:0]      wr_data_i,
  output logic [CFG_W-1:0]      cfg_o,
  output logic [INIT_MSB:0]     rem_o,
  output logic                  expire_o
);
  localparam int unsigned REM_W = INIT_MSB + 1;
  localparam logic [REM_W-1:0] LOW_MASK = {{(REM_W-INIT_LSB){1'b1}}, {INIT_LSB{1'b0}}};

  logic [CFG_W-1:0] cfg_q;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] start_cnt;
  logic             run;

  assign start_cnt = cfg_q[REM_W-1:0] & LOW_MASK;
  assign run       = tick_i && cfg_q[EN_BIT] && !wr_en_i;
  // write takes priority: a tick in the write cycle does not count
  assign expire_o  = run && (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      rem_q <= '0;
    end else if (wr_en_i) begin
      cfg_q <= wr_data_i;
      if (wr_data_i[EN_BIT]) rem_q <= wr_data_i[REM_W-1:0] & LOW_MASK;
    end else if (run) begin
      if (rem_q != '0)           rem_q <= rem_q - 1'b1;
      else if (cfg_q[PER_BIT])   rem_q <= start_cnt;
      else                       cfg_q[EN_BIT] <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;
  assign rem_o = rem_q;

  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[EN_BIT]) |=>
      rem_q == ($past(wr_data_i[REM_W-1:0]) & LOW_MASK));
  a_r5_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cfg_q[EN_BIT] && !wr_en_i && rem_q != '0) |=>
      rem_q == $past(rem_q) - 1'b1);
  a_r6_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q[EN_BIT] && !wr_en_i) |=> $stable(rem_q) && $stable(cfg_q));
  a_r7_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && cfg_q[PER_BIT]) |=> cfg_q[EN_BIT] && rem_q == ($past(cfg_q[REM_W-1:0]) & LOW_MASK));
  a_r8_oneshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !cfg_q[PER_BIT]) |=>
      !cfg_q[EN_BIT] && cfg_q[CFG_W-1:1] == $past(cfg_q[CFG_W-1:1]));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (expire_i) irq_q <= 1'b1;   // set wins over clear
    else if (clr_i)    irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r9_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> irq_q);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !expire_i) |=> !irq_q);
  a_r10_collide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && expire_i) |=> irq_q);
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned CFG_W    = 64,
  parameter int unsigned INIT_MSB = 47,
  parameter int unsigned INIT_LSB = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [63:0] wr_data_i,
  input  logic [1:0]  rd_sel_i,
  output logic [63:0] rd_data_o,
  input  logic        irq_clr_i,
  output logic        irq_o
);
  localparam int unsigned REM_W = INIT_MSB + 1;

  logic [CNT_W-1:0] cnt;
  logic [CFG_W-1:0] cfg;
  logic [REM_W-1:0] rem;
  logic             expire;

  tmr_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt)
  );

  tmr_countdown #(.CFG_W(CFG_W), .INIT_MSB(INIT_MSB), .INIT_LSB(INIT_LSB)) u_cd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i[CFG_W-1:0]),
    .cfg_o     (cfg),
    .rem_o     (rem),
    .expire_o  (expire)
  );

  tmr_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .clr_i    (irq_clr_i),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_sel_e'(rd_sel_i))
      SEL_CNT:  rd_data_o[CNT_W-1:0] = cnt;
      SEL_CFG:  rd_data_o[CFG_W-1:0] = cfg;
      SEL_REM:  rd_data_o[REM_W-1:0] = rem;
      SEL_NONE: rd_data_o = '0;
      default:  rd_data_o = '0;
    endcase
  end

  a_r11_none_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd3) |-> rd_data_o == '0);
endmodule

// File: tb/test_core_tick_timer.sv
`timescale 1ns/1ps
module test_core_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr = 1'b0, clr = 1'b0;
  logic [63:0] wdata = '0;
  logic [1:0]  sel = '0;
  logic [63:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] START_MASK = 64'h0000_FFFF_FFFF_FFFC;

  // reference state
  logic [63:0] m_cnt = '0, m_cfg = '0, m_rem = '0;
  logic        m_irq = 1'b0;

  always #4 clk = ~clk;

  core_tick_timer i_core_tick_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr), .wr_data_i(wdata),
    .rd_sel_i(sel), .rd_data_o(rdata), .irq_clr_i(clr), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [63:0] d);
    sel = s;
    #0.2;
    d = rdata;
  endtask

  function automatic logic m_expire(input logic t, input logic w);
    return t && !w && m_cfg[0] && (m_rem == 0);
  endfunction

  task automatic step(input logic t, input logic w, input logic [63:0] d, input logic c);
    logic e;
    @(negedge clk);
    tick = t; wr = w; wdata = d; clr = c;
    @(posedge clk);
    e = m_expire(t, w);
    if (t) m_cnt++;
    if (w) begin
      m_cfg = d;
      if (d[0]) m_rem = d & START_MASK;
    end else if (t && m_cfg[0]) begin
      if (m_rem != 0)    m_rem--;
      else if (m_cfg[1]) m_rem = m_cfg & START_MASK;
      else               m_cfg[0] = 1'b0;
    end
    if (e) m_irq = 1'b1;
    else if (c) m_irq = 1'b0;
    #1;
    tick = 0; wr = 0; clr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, '0, 1'b0);
  endtask

  task automatic cmp_model();
    logic [63:0] v;
    rd(2'd0, v); chk("R2 counter", v, m_cnt);
    rd(2'd1, v); chk("R3 config", v, m_cfg);
    rd(2'd2, v); chk("R5 remaining", v, m_rem);
    chk("R9 irq", {63'd0, irq}, {63'd0, m_irq});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd1234));
    #20; rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    rd(2'd0, v); chk("R1 counter", v, 0);
    rd(2'd1, v); chk("R1 config", v, 0);
    rd(2'd2, v); chk("R1 remaining", v, 0);
    chk("R1 irq", {63'd0, irq}, 0);

    // R2: counts while disabled, holds without tick
    ticks(5);
    step(1'b0, 1'b0, '0, 1'b0);
    rd(2'd0, v); chk("R2 counter disabled", v, 5);

    // R3: full word stored, start count masked
    step(1'b0, 1'b1, 64'hABCD_0000_0000_000B, 1'b0);
    rd(2'd1, v); chk("R3 stored word", v, 64'hABCD_0000_0000_000B);
    rd(2'd2, v); chk("R3 masked count", v, 8);

    // R5 decrement, R4 restart
    ticks(3);
    rd(2'd2, v); chk("R5 decrement", v, 5);
    step(1'b0, 1'b1, 64'h15, 1'b0);
    rd(2'd2, v); chk("R4 restart", v, 20);

    // R6: disabled write stops
    step(1'b0, 1'b1, 64'h14, 1'b0);
    ticks(30);
    rd(2'd2, v); chk("R6 held", v, 20);
    chk("R6 no irq", {63'd0, irq}, 0);

    // R8 one-shot
    step(1'b0, 1'b1, 64'h9, 1'b0);
    ticks(8);
    rd(2'd2, v); chk("R5 at zero", v, 0);
    chk("R5 no early expiry", {63'd0, irq}, 0);
    ticks(1);
    chk("R9 irq set", {63'd0, irq}, 1);
    rd(2'd1, v); chk("R8 enable cleared", v, 64'h8);
    ticks(4);
    rd(2'd2, v); chk("R8 stays stopped", v, 0);
    chk("R9 sticky", {63'd0, irq}, 1);
    step(1'b0, 1'b0, '0, 1'b1);
    chk("R9 cleared", {63'd0, irq}, 0);

    // R7 periodic + R10 collision
    step(1'b0, 1'b1, 64'h7, 1'b0);
    ticks(4);
    step(1'b1, 1'b0, '0, 1'b1);
    chk("R10 set wins", {63'd0, irq}, 1);
    rd(2'd2, v); chk("R7 reloaded", v, 4);
    rd(2'd1, v); chk("R7 enable kept", v, 64'h7);

    // R4: write in expiring cycle drops the expiry
    step(1'b0, 1'b0, '0, 1'b1);
    ticks(4);
    step(1'b1, 1'b1, 64'h21, 1'b0);
    chk("R4 expiry dropped", {63'd0, irq}, 0);
    rd(2'd2, v); chk("R4 new count", v, 32);

    // R11
    rd(2'd3, v); chk("R11 select 3 zero", v, 0);
    cmp_model();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic t, w, c;
      logic [63:0] d;
      t = ($urandom % 4) != 0;
      w = ($urandom % 25) == 0;
      c = ($urandom % 12) == 0;
      d = ({$urandom, $urandom} & 64'hFFFF_0000_0000_0000) | 64'($urandom % 64);
      step(t, w, d, c);
      cmp_model();
      rd(2'd3, v); chk("R11 select 3", v, 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule